// File: doc/BRIEF.md
# Parallel Flash Bus Timing Controller

This block turns single-word requests from a simple synchronous request port into timed cycles on an asynchronous parallel NOR flash bus. It drives the flash address, chip enable, output enable and write enable, and it controls the bidirectional data pins. Flash command sequences, burst modes and status polling are left to software or to other logic.

Every transfer runs through three phases in a fixed order: an address setup phase, a wait-state phase in which the read or write strobe is low, and a hold phase. Reads and writes share the same timing. Each phase length is set in nanoseconds and turned into whole clock cycles by rounding up against a clock-period parameter. The defaults are a 60 MHz clock with 80 ns setup, 40 ns wait and 20 ns hold, which gives 5, 3 and 2 cycles.

The requester sees a ready signal that is high only while the controller is idle, and a one-cycle response pulse that carries read data on reads and marks completion on writes.

Top module: `pflash_xfer_ctrl`

## Requirements
- R1: Each phase lasts the ceiling of its duration divided by the clock period, with at least one cycle. With the defaults (clock period 16667 ps, 80/40/20 ns) this is setup 5, wait 3 and hold 2 cycles, counted from the first clock edge after acceptance.
- R2: `fl_ce_n` is low from the first setup cycle through the last hold cycle, which is 10 cycles by default. It is high in every idle cycle.
- R3: While `fl_ce_n` is low, `fl_addr` holds the address latched when the request was accepted.
- R4: On a read (`req_write` = 0), `fl_oe_n` is low exactly during the wait phase (cycles 6 to 8 after acceptance by default), and `fl_we_n` stays high.
- R5: On a write (`req_write` = 1), `fl_we_n` is low exactly during the wait phase, and `fl_oe_n` stays high.
- R6: On a write, `fl_dq` carries the accepted write data from the first setup cycle through the last hold cycle.
- R7: On a read, `fl_dq` is sampled on the last clock of the wait phase. `rsp_valid` is then high for exactly one cycle, the first hold cycle, with that word on `rsp_rdata`.
- R8: On a write, `rsp_valid` is high for exactly one cycle, the first idle cycle after the hold phase.
- R9: `req_ready` is high only while idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Requests raised while busy are not taken and do not change the transfer in flight.
- R10: After reset, `req_ready` is high, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are high, and `rsp_valid` is low.
- R11: The controller releases `fl_dq` whenever no write transfer is active, so a read that follows a write returns the word the flash drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (25) | Word address |
| req_wdata | input | DATA_W (16) | Write data |
| req_ready | output | 1 | Controller is idle and can take a request |
| rsp_valid | output | 1 | One-cycle completion or read-data pulse |
| rsp_rdata | output | DATA_W (16) | Read data, valid with `rsp_valid` on reads |
| fl_addr | output | ADDR_W (25) | Flash address pins |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_dq | inout | DATA_W (16) | Flash data pins |

## Verification
The assertions assume that the flash device drives `fl_dq` only while `fl_oe_n` is low, so there is never contention with write data. They also assume that reset is held long enough for the first clock edge to see it. The bench flash model returns an address-derived word only while output enable is low. The stimulus raises `req_valid` only at idle, except in the directed case that keeps it high and changes the request fields on purpose during a busy transfer to show that they are ignored. Random reads and writes over the whole address range cover back-to-back write-then-read turnarounds.

// File: rtl/pflash_pkg.sv
// Shared types and helpers for the parallel flash timing controller.
// Assumes durations in ns and clock period in ps, both positive.
package pflash_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_WAIT  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_t;

    // Ceiling of duration over clock period, never below one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned dur_ns,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (dur_ns * 1000 + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/pflash_phase_timer.sv
// Down-counter that times one bus phase.
// Loading N-1 makes the phase last N cycles; expired is high in the
// last cycle of the phase and while the counter is parked at zero.
module pflash_phase_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pflash_dq_port.sv
// Data pin handling for the flash bus: holds write data, drives the
// pins when enabled, and captures read data on request.
// Assumes the external device drives the pins only while the
// controller has released them.
module pflash_dq_port #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdata_load,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              drive_en,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Keep the write word of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (wdata_load)
            wdata_q <= wdata_in;
    end

    // Sample the pins on the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= dq;
    end

    assign dq    = drive_en ? wdata_q : {DATA_W{1'bz}};
    assign rdata = rdata_q;

endmodule

// File: rtl/pflash_xfer_ctrl.sv
// Parallel NOR flash bus timing controller (top).
// Accepts a single-word read or write at idle, then runs setup, wait
// and hold phases whose cycle counts come from ns parameters and the
// clock period. Chip enable spans all three phases, and the strobe
// is low only in the wait phase. Read data is returned with a one-cycle
// pulse in the first hold cycle; writes complete with a pulse in the
// first idle cycle after hold.
module pflash_xfer_ctrl #(
    parameter int unsigned ADDR_W   = 25,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned CLK_PS   = 16667,
    parameter int unsigned SETUP_NS = 80,
    parameter int unsigned WAIT_NS  = 40,
    parameter int unsigned HOLD_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_we_n,
    inout  wire  [DATA_W-1:0] fl_dq
);
    import pflash_pkg::*;

    localparam int unsigned SETUP_CYC = ns_to_cycles(SETUP_NS, CLK_PS);
    localparam int unsigned WAIT_CYC  = ns_to_cycles(WAIT_NS, CLK_PS);
    localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_PS);
    localparam int unsigned MAX_CYC   =
        (SETUP_CYC > WAIT_CYC) ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                               : ((WAIT_CYC > HOLD_CYC) ? WAIT_CYC : HOLD_CYC);
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LD  = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

    phase_t            phase_q, phase_d;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              accept;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rsp_q;
    logic              rd_capture;

    assign accept     = req_valid && (phase_q == PH_IDLE);
    assign rd_capture = (phase_q == PH_WAIT) && tmr_done && !wr_q;

    // Phase sequencing and timer reload on each phase entry.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE: if (req_valid) begin
                phase_d  = PH_SETUP;
                tmr_load = 1'b1;
                tmr_val  = SETUP_LD;
            end
            PH_SETUP: if (tmr_done) begin
                phase_d  = PH_WAIT;
                tmr_load = 1'b1;
                tmr_val  = WAIT_LD;
            end
            PH_WAIT: if (tmr_done) begin
                phase_d  = PH_HOLD;
                tmr_load = 1'b1;
                tmr_val  = HOLD_LD;
            end
            PH_HOLD: if (tmr_done) begin
                phase_d  = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    // Latch address and direction of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            wr_q   <= req_write;
        end
    end

    // One-cycle response: after the read sample, or on leaving a write's hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= 1'b0;
        else
            rsp_q <= rd_capture || ((phase_q == PH_HOLD) && tmr_done && wr_q);
    end

    pflash_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    pflash_dq_port #(.DATA_W(DATA_W)) u_dq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdata_load (accept),
        .wdata_in   (req_wdata),
        .drive_en   (wr_q && (phase_q != PH_IDLE)),
        .capture    (rd_capture),
        .rdata      (rsp_rdata),
        .dq         (fl_dq)
    );

    assign req_ready = (phase_q == PH_IDLE);
    assign rsp_valid = rsp_q;
    assign fl_addr   = addr_q;
    assign fl_ce_n   = (phase_q == PH_IDLE);
    assign fl_oe_n   = !((phase_q == PH_WAIT) && !wr_q);
    assign fl_we_n   = !((phase_q == PH_WAIT) && wr_q);

endmodule

// File: rtl/pflash_xfer_chk.sv
// Protocol checker for the flash timing controller, bound to the top.
// Measures strobe and chip-enable windows with counters, so no
// parameter-sized temporal delays are needed.
module pflash_xfer_chk #(
    parameter int unsigned ADDR_W   = 25,
    parameter int unsigned CLK_PS   = 16667,
    parameter int unsigned SETUP_NS = 80,
    parameter int unsigned WAIT_NS  = 40,
    parameter int unsigned HOLD_NS  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              fl_ce_n,
    input logic              fl_oe_n,
    input logic              fl_we_n
);
    import pflash_pkg::*;

    localparam int unsigned WAIT_CYC  = ns_to_cycles(WAIT_NS, CLK_PS);
    localparam int unsigned TOTAL_CYC = ns_to_cycles(SETUP_NS, CLK_PS) +
                                        WAIT_CYC + ns_to_cycles(HOLD_NS, CLK_PS);

    logic        strobe;
    logic        strobe_q, ce_q;
    logic [15:0] strobe_cnt, ce_cnt;

    assign strobe = !fl_oe_n || !fl_we_n;

    // Run lengths of the strobe-low and chip-enable-low windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q   <= 1'b0;
            ce_q       <= 1'b0;
            strobe_cnt <= '0;
            ce_cnt     <= '0;
        end else begin
            strobe_q   <= strobe;
            ce_q       <= !fl_ce_n;
            strobe_cnt <= strobe ? strobe_cnt + 16'd1 : 16'd0;
            ce_cnt     <= !fl_ce_n ? ce_cnt + 16'd1 : 16'd0;
        end
    end

    a_r1_wait_len: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_q && !strobe) |-> (strobe_cnt == 16'(WAIT_CYC)));

    a_r2_ce_len: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_q && fl_ce_n) |-> (ce_cnt == 16'(TOTAL_CYC)));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_ce_n && ce_q) |-> $stable(fl_addr));

    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_oe_n && !fl_we_n));

    a_r4_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !fl_ce_n);

    a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == fl_ce_n);

endmodule

bind pflash_xfer_ctrl pflash_xfer_chk #(
    .ADDR_W   (ADDR_W),
    .CLK_PS   (CLK_PS),
    .SETUP_NS (SETUP_NS),
    .WAIT_NS  (WAIT_NS),
    .HOLD_NS  (HOLD_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .fl_addr   (fl_addr),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n)
);

// File: tb/pflash_xfer_ctrl_test.sv
`timescale 1ns/1ps
module pflash_xfer_ctrl_test;
    localparam real CLK_PERIOD = 16.667;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [24:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [24:0] fl_addr;
    logic        fl_ce_n, fl_oe_n, fl_we_n;
    wire  [15:0] fl_dq;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    function automatic int cyc_of(input int ns);
        return (ns * 1000 + 16667 - 1) / 16667;
    endfunction

    function automatic logic [15:0] flash_word(input logic [24:0] a);
        return a[15:0] ^ 16'h5A3C ^ {7'b0, a[24:16]};
    endfunction

    // Flash model: drives the data pins only while output enable is low.
    assign fl_dq = !fl_oe_n ? flash_word(fl_addr) : 16'hzzzz;

    pflash_xfer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fl_addr(fl_addr),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_dq(fl_dq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One transfer checked cycle by cycle; busy_poke keeps req_valid high and
    // changes the request fields while busy (R9).
    task automatic run_xfer(input bit wr, input logic [24:0] a, input logic [15:0] d,
                            input bit busy_poke);
        int su = cyc_of(80);
        int wt = cyc_of(40);
        int tt = su + wt + cyc_of(20);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready before request", {31'b0, req_ready}, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (busy_poke) begin
            req_addr = a ^ 25'h0155_5555; req_write = !wr; req_wdata = ~d;
        end else
            req_valid = 1'b0;
        for (int k = 1; k <= tt + 2; k++) begin
            bit exp_ce  = (k <= tt);
            bit in_wait = (k > su) && (k <= su + wt);
            bit exp_ack = wr ? (k == tt + 1) : (k == su + wt + 1);
            check(fl_ce_n == !exp_ce, "R2 ce_n", {31'b0, fl_ce_n}, {31'b0, !exp_ce});
            check(fl_oe_n == !(in_wait && !wr), "R1 R4 oe_n", {31'b0, fl_oe_n},
                  {31'b0, !(in_wait && !wr)});
            check(fl_we_n == !(in_wait && wr), "R1 R5 we_n", {31'b0, fl_we_n},
                  {31'b0, !(in_wait && wr)});
            check(req_ready == !exp_ce, "R9 ready", {31'b0, req_ready}, {31'b0, !exp_ce});
            if (exp_ce)
                check(fl_addr == a, "R3 addr", {7'b0, fl_addr}, {7'b0, a});
            if (exp_ce && wr)
                check(fl_dq == d, "R6 write data", {16'b0, fl_dq}, {16'b0, d});
            check(rsp_valid == exp_ack, wr ? "R8 write ack" : "R7 read ack",
                  {31'b0, rsp_valid}, {31'b0, exp_ack});
            if (exp_ack && !wr)
                check(rsp_rdata == flash_word(a), "R7 R11 read data",
                      {16'b0, rsp_rdata}, {16'b0, flash_word(a)});
            if (busy_poke && k == tt) req_valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(req_ready == 1'b1, "R10 ready", {31'b0, req_ready}, 1);
        check(fl_ce_n == 1'b1, "R10 ce_n", {31'b0, fl_ce_n}, 1);
        check(fl_oe_n == 1'b1 && fl_we_n == 1'b1, "R10 strobes",
              {30'b0, fl_oe_n, fl_we_n}, 3);
        check(rsp_valid == 1'b0, "R10 rsp_valid", {31'b0, rsp_valid}, 0);
        // Directed corners
        run_xfer(1'b0, 25'h0000000, 16'h0000, 1'b0);
        run_xfer(1'b1, 25'h1FFFFFF, 16'hFFFF, 1'b0);
        run_xfer(1'b0, 25'h1FFFFFF, 16'h0000, 1'b0);  // R11 read after write
        run_xfer(1'b1, 25'h0AAAAAA, 16'hA5A5, 1'b1);  // R9 busy poke
        run_xfer(1'b0, 25'h1555555, 16'h0000, 1'b1);  // R9 busy poke on read
        // Random mix
        for (int i = 0; i < 40; i++)
            run_xfer(1'($urandom), 25'($urandom), 16'($urandom), 1'b0);
        summary();
        $finish;
    end
endmodule